// File: doc/BRIEF.md
# Shared Fault Line Pin Controller

This block manages one pin that several power-sequencing devices share as a wired-AND fault line. The line idles high through an external pull-up. While the local device has no fault, the pin only listens to the line. When the local logic flags a rail fault, the block turns on the pad's output enable. The pad's output value is tied to zero, so the pin pulls the line low and every other device on the line learns of the fault and can respond. Once the local fault has gone away and has been acknowledged, the block turns the driver off and the pin listens again.

The block also tells a remote fault apart from its own drive. The pad input passes through a synchronizer and a qualification counter whose length is set at run time. A remote fault is reported only when the line has been low for long enough while this block has not been driving it. This also covers the few cycles after a release, while the synchronizer still shows the block's own low level. A feature enable turns the whole function on or off. A debug flag stops the pin from ever pulling the line and suppresses remote-fault reporting.

Top module: `fbus_pin_ctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pad_oe_o` and `remote_fault_o` are 0.
- R2: When `local_fault_i` is 1 at a rising edge with `bus_en_i`=1 and `debug_i`=0, `pad_oe_o` is 1 after that edge.
- R3: A local fault is held after `local_fault_i` falls. The hold is released only by `fault_clear_i`=1 at an edge where `local_fault_i`=0, and `pad_oe_o` falls after that edge. A clear given while `local_fault_i`=1 has no effect.
- R4: While `bus_en_i`=0, `pad_oe_o` and `remote_fault_o` stay 0 after each edge and any held local fault is discarded. When the block is enabled again, it does not drive until a new local fault arrives.
- R5: While `debug_i`=1, `pad_oe_o` and `remote_fault_o` are 0 after each edge. A held local fault survives debug, and driving resumes one edge after `debug_i` returns to 0.
- R6: With the line held low by another device from just before edge 1, `remote_fault_o` first reads 1 after edge SYNC_STAGES+`filt_len_i`+1. A single high cycle on the line restarts this count from the edge after the line is low again.
- R7: The line being low because of the block's own drive never raises `remote_fault_o`. This includes the SYNC_STAGES cycles after the driver turns off.
- R8: After the line returns high, `remote_fault_o` falls after edge SYNC_STAGES+1.
- R9: `pad_o` is always 0, so the pad can only pull the line low or release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Turns the fault-line function on |
| debug_i | input | 1 | Debug mode: never drive the line, report no remote fault |
| local_fault_i | input | 1 | Local rail fault flag |
| fault_clear_i | input | 1 | Acknowledge that releases a held local fault |
| filt_len_i | input | FILT_W | Extra low cycles needed before a remote fault is reported |
| pad_i | input | 1 | Raw pad input from the shared line |
| pad_oe_o | output | 1 | Pad output enable (1 = pull the line low) |
| pad_o | output | 1 | Pad output value, always 0 |
| remote_fault_o | output | 1 | Another device is pulling the line low |

## Verification
The drive path is tested with four patterns: a short fault pulse, a clear given while the fault is still active, a fault that arrives while the feature is disabled, and a fault held across a debug window. Together these separate a held fault from a level-following one and show which input wins. The remote path is tested with a steady external low at two filter lengths, which checks the exact latency formula. A one-cycle high glitch shows that the count restarts rather than pauses. A release timing check and a long self-drive followed by a release separate a true remote fault from the block's own level as it travels through the synchronizer.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef enum logic {
    PIN_LISTEN = 1'b0,
    PIN_PULL   = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/fbus_sync.sv
module fbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fbus_drive_ctl.sv
module fbus_drive_ctl
  import fbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic debug,
  input  logic local_fault,
  input  logic fault_clear,
  output logic oe
);
  pin_mode_e mode_q, mode_d;

  // A fault is held until acknowledged; disabling discards it.
  always_comb begin
    mode_d = mode_q;
    if (!enable)
      mode_d = PIN_LISTEN;
    else if (local_fault)
      mode_d = PIN_PULL;
    else if (fault_clear)
      mode_d = PIN_LISTEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PIN_LISTEN;
      oe     <= 1'b0;
    end else begin
      mode_q <= mode_d;
      oe     <= (mode_d == PIN_PULL) && enable && !debug;
    end
  end
endmodule

// File: rtl/fbus_remote_filt.sv
module fbus_remote_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             debug,
  input  logic             bus_sync,
  input  logic             own_oe,
  input  logic [CNT_W-1:0] filt_len,
  output logic             remote
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Own drive delayed to line up with the synchronizer latency.
  logic [SYNC_STAGES-1:0] own_dly;
  logic                   own_busy;
  logic                   qual;
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk) begin
    if (rst) own_dly <= '0;
    else     own_dly <= {own_dly[SYNC_STAGES-2:0], own_oe};
  end

  assign own_busy = own_oe || (|own_dly);
  assign qual     = enable && !debug && !bus_sync && !own_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      remote <= 1'b0;
    end else if (!qual) begin
      cnt    <= '0;
      remote <= 1'b0;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      remote <= (cnt >= filt_len);
    end
  end
endmodule

// File: rtl/fbus_pin_ctl.sv
module fbus_pin_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en_i,
  input  logic              debug_i,
  input  logic              local_fault_i,
  input  logic              fault_clear_i,
  input  logic [FILT_W-1:0] filt_len_i,
  input  logic              pad_i,
  output logic              pad_oe_o,
  output logic              pad_o,
  output logic              remote_fault_o
);
  logic bus_sync;

  fbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_i),
    .q   (bus_sync)
  );

  fbus_drive_ctl u_drive (
    .clk         (clk),
    .rst         (rst),
    .enable      (bus_en_i),
    .debug       (debug_i),
    .local_fault (local_fault_i),
    .fault_clear (fault_clear_i),
    .oe          (pad_oe_o)
  );

  fbus_remote_filt #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(FILT_W)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .enable   (bus_en_i),
    .debug    (debug_i),
    .bus_sync (bus_sync),
    .own_oe   (pad_oe_o),
    .filt_len (filt_len_i),
    .remote   (remote_fault_o)
  );

  // Open-drain: the value is always low, only the enable toggles.
  assign pad_o = 1'b0;
endmodule

// File: rtl/fbus_pin_ctl_chk.sv
module fbus_pin_ctl_chk (
  input logic clk,
  input logic rst,
  input logic bus_en_i,
  input logic debug_i,
  input logic local_fault_i,
  input logic fault_clear_i,
  input logic pad_oe_o,
  input logic remote_fault_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pad_oe_o && !remote_fault_o));

  a_r2_fault_drives: assert property (@(posedge clk) disable iff (rst)
    (bus_en_i && !debug_i && local_fault_i) |=> pad_oe_o);

  a_r3_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
    (pad_oe_o && bus_en_i && !debug_i && !fault_clear_i) |=> pad_oe_o);

  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !bus_en_i |=> (!pad_oe_o && !remote_fault_o));

  a_r5_debug_silent: assert property (@(posedge clk) disable iff (rst)
    debug_i |=> (!pad_oe_o && !remote_fault_o));

  a_r7_own_drive_not_remote: assert property (@(posedge clk) disable iff (rst)
    (pad_oe_o && $past(pad_oe_o)) |-> !remote_fault_o);
endmodule

bind fbus_pin_ctl fbus_pin_ctl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_en_i       (bus_en_i),
  .debug_i        (debug_i),
  .local_fault_i  (local_fault_i),
  .fault_clear_i  (fault_clear_i),
  .pad_oe_o       (pad_oe_o),
  .remote_fault_o (remote_fault_o)
);

// File: tb/fbus_pin_ctl_bench.sv
module fbus_pin_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int FW         = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_en, debug, local_f, clr;
  logic [FW-1:0] filt_len;
  logic          ext_low;
  logic          pad_in, pad_oe, pad_out, remote;
  int            n_checks = 0;
  int            n_fails  = 0;
  bit            done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Wired-AND line with pull-up: low if anyone drives.
  assign pad_in = ~(pad_oe | ext_low);

  fbus_pin_ctl #(.SYNC_STAGES(SYNC), .FILT_W(FW)) u_fbus_pin_ctl (
    .clk            (clk),
    .rst            (rst),
    .bus_en_i       (bus_en),
    .debug_i        (debug),
    .local_fault_i  (local_f),
    .fault_clear_i  (clr),
    .filt_len_i     (filt_len),
    .pad_i          (pad_in),
    .pad_oe_o       (pad_oe),
    .pad_o          (pad_out),
    .remote_fault_o (remote)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; bus_en = 1'b1; debug = 1'b0; local_f = 1'b0; clr = 1'b0;
    filt_len = '0; ext_low = 1'b0;
    tick(3);
    chk("R1 oe in reset", pad_oe, 0);
    chk("R1 remote in reset", remote, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 oe after reset", pad_oe, 0);
    chk("R9 pad value", pad_out, 0);
    tick(4);
  endtask

  task automatic t_pulse_fault;
    local_f = 1'b1; tick(1);
    chk("R2 drive after fault", pad_oe, 1);
    chk("R9 pad value while driving", pad_out, 0);
    local_f = 1'b0; tick(3);
    chk("R3 held after fault drops", pad_oe, 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R3 released by clear", pad_oe, 0);
    tick(4);
  endtask

  task automatic t_clear_while_active;
    local_f = 1'b1; clr = 1'b1; tick(2);
    chk("R3 clear ignored during fault", pad_oe, 1);
    clr = 1'b0; local_f = 1'b0; tick(1);
    chk("R3 still held", pad_oe, 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R3 second clear releases", pad_oe, 0);
    tick(4);
  endtask

  task automatic t_disabled;
    bit seen = 1'b0;
    bus_en = 1'b0; local_f = 1'b1; ext_low = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (pad_oe || remote) seen = 1'b1;
    end
    chk("R4 silent while disabled", seen, 0);
    local_f = 1'b0; ext_low = 1'b0; bus_en = 1'b1;
    tick(3);
    chk("R4 fault discarded on re-enable", pad_oe, 0);
    tick(4);
  endtask

  task automatic t_debug;
    bit seen = 1'b0;
    local_f = 1'b1; tick(1);
    chk("R5 drive before debug", pad_oe, 1);
    debug = 1'b1; tick(1);
    chk("R5 no drive in debug", pad_oe, 0);
    local_f = 1'b0; ext_low = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (pad_oe || remote) seen = 1'b1;
    end
    chk("R5 silent through debug", seen, 0);
    ext_low = 1'b0; tick(SYNC + 1);
    debug = 1'b0; tick(1);
    chk("R5 held fault resumes", pad_oe, 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R5 release after debug", pad_oe, 0);
    tick(6);
  endtask

  task automatic t_latency(input int len);
    int edges = 0;
    filt_len = FW'(len);
    tick(6);
    ext_low = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      edges++;
      if (remote) break;
    end
    chk($sformatf("R6 latency len=%0d", len), edges, SYNC + len + 1);
    // release timing
    ext_low = 1'b0; tick(SYNC);
    chk("R8 remote held during sync", remote, 1);
    tick(1);
    chk("R8 remote falls", remote, 0);
    tick(4);
  endtask

  task automatic t_glitch;
    int edges = 0;
    filt_len = FW'(5);
    tick(6);
    ext_low = 1'b1; tick(4);
    ext_low = 1'b0; tick(1);
    chk("R6 no remote before glitch", remote, 0);
    ext_low = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      edges++;
      if (remote) break;
    end
    chk("R6 count restarts after glitch", edges, SYNC + 5 + 1);
    ext_low = 1'b0; tick(6);
  endtask

  task automatic t_self_drive;
    bit seen = 1'b0;
    bit seen2 = 1'b0;
    filt_len = '0;
    local_f = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (remote) seen = 1'b1;
    end
    chk("R7 no remote while driving", seen, 0);
    local_f = 1'b0; clr = 1'b1; tick(1); clr = 1'b0;
    chk("R7 driver released", pad_oe, 0);
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (remote) seen2 = 1'b1;
    end
    chk("R7 no remote after release", seen2, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pulse_fault();
    t_clear_while_active();
    t_disabled();
    t_debug();
    t_latency(0);
    t_latency(3);
    t_glitch();
    t_self_drive();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule